// File: doc/BRIEF.md
# Tiled Address Channel Swizzler

This block rewrites bit 6 of a byte address so that tiled surfaces land on the right memory channel of a dual-channel interleaved memory. The memory controller steers alternate 64-byte chunks to alternate channels. Tiled engines walk memory in two dimensions, so the channel bit must be XORed with a set of higher address bits. Which bits are used depends on the channel organisation, on whether the controller adds its own XOR term, and on whether the surface is X-tiled or Y-tiled.

Configuration pins describe the memory organisation. The block turns them into one swizzle mode for X-tiled surfaces and one for Y-tiled surfaces. The organisation can be given directly (single, asymmetric dual, interleaved dual, plus a controller XOR term built from bit 11 or bit 17). It can also be inferred by comparing the populated size of the two channels. A flag marks a configuration read that came back as all ones. In that case the swizzle is unknown, and tiled requests fall back to untiled.

Requests arrive on a valid/ready stream carrying an address and a tiling kind. Each accepted request yields exactly one result one cycle later: the remapped address, the effective tiling kind, the applied mode code, and a reduced mode code for software that hides the bit-17 term. A result is held unchanged while `out_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a result leaves and a new request enters on the same edge. The configuration is sampled on the edge at which a request is accepted. A change while a result waits does not alter that result.

Top module: `chan_swizzle_xlat`

## Requirements
- R1: A request with tiling code 0 (linear) or 3 (reserved) returns its address unchanged, `out_tile` = 0 and `out_mode` = 0.
- R2: With `cfg_org` = 0 (single), 1 (asymmetric dual) or 3 (reserved), and `cfg_use_size` = 0, tiled requests get mode 0 and an unchanged address, and keep their tiling code.
- R3: With `cfg_org` = 2 (interleaved) and `cfg_xor_off` = 1, X-tiled (code 1) requests get mode 2 and bit 6 ^= a9^a10. Y-tiled (code 2) requests get mode 1 and bit 6 ^= a9.
- R4: With interleaved, `cfg_xor_off` = 0 and `cfg_xor_hi17` = 0: X gets mode 4 (bit 6 ^= a9^a10^a11), Y gets mode 3 (bit 6 ^= a9^a11).
- R5: With interleaved, `cfg_xor_off` = 0 and `cfg_xor_hi17` = 1: X gets mode 6 (bit 6 ^= a9^a10^a17), Y gets mode 5 (bit 6 ^= a9^a17).
- R6: With `cfg_read_fail` = 1 both modes are unknown (code 7). A tiled request then falls back: `out_tile` = 0, `out_mode` = 0, address unchanged. `out_mode` is never 7.
- R7: `out_user_mode` equals `out_mode`, except that 5 reports as 1 and 6 reports as 2.
- R8: With `cfg_use_size` = 1 (and no read failure), equal `cfg_size_ch0`/`cfg_size_ch1` give X mode 2 and Y mode 1. Unequal sizes give mode 0 for both.
- R9: An accepted request produces `out_valid` on the next edge. While `out_valid` && !`out_ready`, the output stays stable and `in_ready` is low.
- R10: During reset `out_valid` is 0. After reset, with nothing held, `in_ready` is 1.
- R11: Configuration is sampled only when a request is accepted. Changing it while a result is held does not change that result, and applies to the next request.
- R12: Only bit 6 of the address may differ between request and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_org | input | 2 | Channel organisation: 0 single, 1 asymmetric dual, 2 interleaved dual, 3 reserved |
| cfg_xor_off | input | 1 | Controller channel XOR disabled |
| cfg_xor_hi17 | input | 1 | Controller XOR term uses bit 17 (1) or bit 11 (0) |
| cfg_read_fail | input | 1 | Configuration read returned all ones |
| cfg_use_size | input | 1 | Infer organisation from channel size comparison |
| cfg_size_ch0 | input | SW | Populated size of channel 0 |
| cfg_size_ch1 | input | SW | Populated size of channel 1 |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | AW | Request byte address (AW >= 18) |
| in_tile | input | 2 | Tiling: 0 linear, 1 X, 2 Y, 3 reserved |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_addr | output | AW | Remapped address |
| out_tile | output | 2 | Effective tiling after fallback |
| out_mode | output | 3 | Applied mode: 0 none, 1 b9, 2 b9+10, 3 b9+11, 4 b9+10+11, 5 b9+17, 6 b9+10+17 |
| out_user_mode | output | 3 | Mode code with bit-17 term removed |

## Verification
The bench targets the pairs of modes that differ by a single term. Its addresses have bits 10, 11 and 17 set alone, so a design that mixes up X and Y, or bit 11 and bit 17, flips bit 6 wrongly. The read-failure case checks that tiling falls back to linear instead of passing code 7 or swizzling. A stalled result is checked while the configuration and pending request change under it. A design that decodes configuration at the output instead of at acceptance would change the held mode. A design that drops the overlap of drain and accept would lose or duplicate the next request.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_9        = 3'd1,
    SWZ_9_10     = 3'd2,
    SWZ_9_11     = 3'd3,
    SWZ_9_10_11  = 3'd4,
    SWZ_9_17     = 3'd5,
    SWZ_9_10_17  = 3'd6,
    SWZ_UNKNOWN  = 3'd7
  } swz_mode_e;

  typedef enum logic [1:0] {
    TILE_LIN = 2'd0,
    TILE_X   = 2'd1,
    TILE_Y   = 2'd2,
    TILE_RSV = 2'd3
  } tile_e;

  typedef enum logic [1:0] {
    ORG_SINGLE = 2'd0,
    ORG_ASYM   = 2'd1,
    ORG_INTLV  = 2'd2,
    ORG_RSV    = 2'd3
  } chan_org_e;

  // Software-facing view: the bit-17 term is handled elsewhere, so hide it.
  function automatic swz_mode_e user_view(input swz_mode_e m);
    case (m)
      SWZ_9_17:    return SWZ_9;
      SWZ_9_10_17: return SWZ_9_10;
      default:     return m;
    endcase
  endfunction

endpackage

// File: rtl/swz_mode_decode.sv
module swz_mode_decode
  import swz_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic [1:0]    org,
  input  logic          xor_off,
  input  logic          xor_hi17,
  input  logic          read_fail,
  input  logic          use_size,
  input  logic [SW-1:0] size_ch0,
  input  logic [SW-1:0] size_ch1,
  output swz_mode_e     x_mode,
  output swz_mode_e     y_mode
);

  always_comb begin
    x_mode = SWZ_NONE;
    y_mode = SWZ_NONE;
    if (read_fail) begin
      x_mode = SWZ_UNKNOWN;
      y_mode = SWZ_UNKNOWN;
    end else if (use_size) begin
      if (size_ch0 == size_ch1) begin
        x_mode = SWZ_9_10;
        y_mode = SWZ_9;
      end
    end else if (org == ORG_INTLV) begin
      if (xor_off) begin
        x_mode = SWZ_9_10;
        y_mode = SWZ_9;
      end else if (xor_hi17) begin
        x_mode = SWZ_9_10_17;
        y_mode = SWZ_9_17;
      end else begin
        x_mode = SWZ_9_10_11;
        y_mode = SWZ_9_11;
      end
    end
  end

endmodule

// File: rtl/swz_bit6_remap.sv
module swz_bit6_remap
  import swz_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  swz_mode_e     mode_i,
  output logic [AW-1:0] addr_o
);

  logic use9, use10, use11, use17;
  logic bit17;
  logic flip;

  generate
    if (AW > 17) begin : g_hi
      assign bit17 = addr_i[17];
    end else begin : g_lo
      assign bit17 = 1'b0;
    end
  endgenerate

  always_comb begin
    use9  = 1'b0;
    use10 = 1'b0;
    use11 = 1'b0;
    use17 = 1'b0;
    case (mode_i)
      SWZ_9:       use9 = 1'b1;
      SWZ_9_10:    begin use9 = 1'b1; use10 = 1'b1; end
      SWZ_9_11:    begin use9 = 1'b1; use11 = 1'b1; end
      SWZ_9_10_11: begin use9 = 1'b1; use10 = 1'b1; use11 = 1'b1; end
      SWZ_9_17:    begin use9 = 1'b1; use17 = 1'b1; end
      SWZ_9_10_17: begin use9 = 1'b1; use10 = 1'b1; use17 = 1'b1; end
      default:     ;
    endcase
    flip = (use9 & addr_i[9]) ^ (use10 & addr_i[10]) ^
           (use11 & addr_i[11]) ^ (use17 & bit17);
    addr_o    = addr_i;
    addr_o[6] = addr_i[6] ^ flip;
  end

endmodule

// File: rtl/swz_out_slice.sv
module swz_out_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R9: a stalled result is held
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: accepted request shows up next cycle
  p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9: no acceptance while stalled
  p_backpr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/chan_swizzle_xlat.sv
module chan_swizzle_xlat
  import swz_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_org,
  input  logic          cfg_xor_off,
  input  logic          cfg_xor_hi17,
  input  logic          cfg_read_fail,
  input  logic          cfg_use_size,
  input  logic [SW-1:0] cfg_size_ch0,
  input  logic [SW-1:0] cfg_size_ch1,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [1:0]    in_tile,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [1:0]    out_tile,
  output logic [2:0]    out_mode,
  output logic [2:0]    out_user_mode
);

  localparam int PW = AW + 2 + 3 + 3;

  swz_mode_e     x_mode, y_mode, sel_mode, eff_mode;
  tile_e         eff_tile;
  logic          tiled;
  logic [AW-1:0] new_addr;
  logic [PW-1:0] pay_in, pay_out;

  swz_mode_decode #(.SW(SW)) u_decode (
    .org      (cfg_org),
    .xor_off  (cfg_xor_off),
    .xor_hi17 (cfg_xor_hi17),
    .read_fail(cfg_read_fail),
    .use_size (cfg_use_size),
    .size_ch0 (cfg_size_ch0),
    .size_ch1 (cfg_size_ch1),
    .x_mode   (x_mode),
    .y_mode   (y_mode)
  );

  always_comb begin
    tiled    = (in_tile == TILE_X) || (in_tile == TILE_Y);
    sel_mode = (in_tile == TILE_X) ? x_mode : y_mode;
    if (!tiled || sel_mode == SWZ_UNKNOWN) begin
      eff_mode = SWZ_NONE;
      eff_tile = TILE_LIN;
    end else begin
      eff_mode = sel_mode;
      eff_tile = tile_e'(in_tile);
    end
  end

  swz_bit6_remap #(.AW(AW)) u_remap (
    .addr_i(in_addr),
    .mode_i(eff_mode),
    .addr_o(new_addr)
  );

  assign pay_in = {new_addr, eff_tile, eff_mode, user_view(eff_mode)};

  swz_out_slice #(.W(PW)) u_slice (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (pay_in),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (pay_out)
  );

  assign {out_addr, out_tile, out_mode, out_user_mode} = pay_out;

  // R6: a failed configuration read never leaves a tiled or swizzled result
  p_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cfg_read_fail) |=>
      (out_tile == 2'd0 && out_mode == 3'd0 && out_addr == $past(in_addr)));

  // R6: the unknown code never escapes
  p_no_unknown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mode != 3'd7));

  // R7: user view has no bit-17 codes
  p_user_hide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_user_mode != 3'd5 && out_user_mode != 3'd6));

  // R1: linear and reserved tiling pass through untouched
  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_tile == 2'd0 || in_tile == 2'd3)) |=>
      (out_addr == $past(in_addr) && out_tile == 2'd0));

  // R12: only bit 6 may change
  p_bit6_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (((out_addr ^ $past(in_addr)) & ~(AW'(1) << 6)) == '0));

endmodule

// File: tb/test_chan_swizzle_xlat.sv
`timescale 1ns/1ps
module test_chan_swizzle_xlat;

  localparam int AW = 32;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cfg_org;
  logic          cfg_xor_off, cfg_xor_hi17, cfg_read_fail, cfg_use_size;
  logic [SW-1:0] cfg_size_ch0, cfg_size_ch1;
  logic          in_valid, in_ready, out_valid, out_ready;
  logic [AW-1:0] in_addr, out_addr;
  logic [1:0]    in_tile, out_tile;
  logic [2:0]    out_mode, out_user_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chan_swizzle_xlat #(.AW(AW), .SW(SW)) i_chan_swizzle_xlat (
    .clk(clk), .rst_n(rst_n),
    .cfg_org(cfg_org), .cfg_xor_off(cfg_xor_off), .cfg_xor_hi17(cfg_xor_hi17),
    .cfg_read_fail(cfg_read_fail), .cfg_use_size(cfg_use_size),
    .cfg_size_ch0(cfg_size_ch0), .cfg_size_ch1(cfg_size_ch1),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_tile(in_tile),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_tile(out_tile), .out_mode(out_mode), .out_user_mode(out_user_mode)
  );

  typedef struct packed {
    logic [1:0]  org;
    logic        xo;
    logic        h17;
    logic        fl;
    logic        us;
    logic [7:0]  s0;
    logic [7:0]  s1;
    logic [1:0]  tl;
    logic [31:0] ad;
    logic [2:0]  em;
    logic [2:0]  eu;
    logic [1:0]  et;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{2'd2,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,2'd1,32'h0000_0200,3'd2,3'd2,2'd1}, // R3 X
    '{2'd2,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,2'd2,32'h0000_0640,3'd1,3'd1,2'd2}, // R3 Y
    '{2'd2,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,2'd1,32'h0000_0E00,3'd4,3'd4,2'd1}, // R4 X
    '{2'd2,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,2'd2,32'h0000_0800,3'd3,3'd3,2'd2}, // R4 Y
    '{2'd2,1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,2'd1,32'h0002_0000,3'd6,3'd2,2'd1}, // R5 R7 X
    '{2'd2,1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,2'd2,32'h0002_0A40,3'd5,3'd1,2'd2}, // R5 R7 Y
    '{2'd0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,2'd1,32'h0002_0E40,3'd0,3'd0,2'd1}, // R2 single
    '{2'd1,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,2'd2,32'h0002_0E40,3'd0,3'd0,2'd2}, // R2 asym
    '{2'd3,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,2'd1,32'h0000_0E00,3'd0,3'd0,2'd1}, // R2 reserved
    '{2'd2,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,2'd0,32'h0000_0E7F,3'd0,3'd0,2'd0}, // R1 linear
    '{2'd2,1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,2'd3,32'h0002_0E7F,3'd0,3'd0,2'd0}, // R1 reserved tile
    '{2'd2,1'b0,1'b1,1'b1,1'b0,8'h00,8'h00,2'd1,32'h0002_0600,3'd0,3'd0,2'd0}, // R6 fallback
    '{2'd0,1'b0,1'b0,1'b0,1'b1,8'h40,8'h40,2'd1,32'h0000_0200,3'd2,3'd2,2'd1}, // R8 equal X
    '{2'd2,1'b0,1'b0,1'b0,1'b1,8'h40,8'h40,2'd2,32'h0000_0E00,3'd1,3'd1,2'd2}, // R8 equal Y
    '{2'd2,1'b0,1'b0,1'b0,1'b1,8'h40,8'h20,2'd2,32'h0000_0E00,3'd0,3'd0,2'd2}  // R8 unequal
  };

  // Expected address from the mode definitions in R3..R5
  function automatic logic [31:0] ref_addr(input logic [31:0] a, input logic [2:0] m);
    logic f;
    case (m)
      3'd1: f = a[9];
      3'd2: f = a[9] ^ a[10];
      3'd3: f = a[9] ^ a[11];
      3'd4: f = a[9] ^ a[10] ^ a[11];
      3'd5: f = a[9] ^ a[17];
      3'd6: f = a[9] ^ a[10] ^ a[17];
      default: f = 1'b0;
    endcase
    ref_addr = a ^ {25'd0, f, 6'd0};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input vec_t v);
    cfg_org = v.org; cfg_xor_off = v.xo; cfg_xor_hi17 = v.h17;
    cfg_read_fail = v.fl; cfg_use_size = v.us;
    cfg_size_ch0 = v.s0; cfg_size_ch1 = v.s1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_addr = '0; in_tile = '0;
    set_cfg(TBL[0]);
    repeat (3) @(negedge clk);
    check("R10 reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle in_ready", 64'(in_ready), 64'd1);
    check("R10 idle out_valid", 64'(out_valid), 64'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      set_cfg(TBL[i]);
      in_addr = TBL[i].ad; in_tile = TBL[i].tl; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R9 row%0d valid", i), 64'(out_valid), 64'd1);
      check($sformatf("R12 row%0d addr", i), 64'(out_addr), 64'(ref_addr(TBL[i].ad, TBL[i].em)));
      check($sformatf("R3-5 row%0d mode", i), 64'(out_mode), 64'(TBL[i].em));
      check($sformatf("R7 row%0d user", i), 64'(out_user_mode), 64'(TBL[i].eu));
      check($sformatf("R6 row%0d tile", i), 64'(out_tile), 64'(TBL[i].et));
    end
    @(negedge clk);
    check("R9 drained", 64'(out_valid), 64'd0);

    // Back-pressure and config sampling (R9, R11)
    out_ready = 1'b0;
    set_cfg(TBL[2]);
    in_addr = 32'h0000_0E00; in_tile = 2'd1; in_valid = 1'b1;
    @(negedge clk);
    check("R9 stall valid", 64'(out_valid), 64'd1);
    check("R9 stall in_ready", 64'(in_ready), 64'd0);
    check("R4 stall mode", 64'(out_mode), 64'd4);
    set_cfg(TBL[0]);
    in_addr = 32'h0000_0200; in_tile = 2'd1;
    @(negedge clk);
    @(negedge clk);
    check("R11 held mode", 64'(out_mode), 64'd4);
    check("R11 held addr", 64'(out_addr), 64'(ref_addr(32'h0000_0E00, 3'd4)));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 overlap valid", 64'(out_valid), 64'd1);
    check("R11 new mode", 64'(out_mode), 64'd2);
    check("R11 new addr", 64'(out_addr), 64'h0000_0240);
    @(negedge clk);
    check("R9 empty after drain", 64'(out_valid), 64'd0);

    // Unknown under Y with bit 9 set: must not swizzle (R6)
    set_cfg(TBL[11]);
    in_addr = 32'h0000_0240; in_tile = 2'd2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 Y fallback addr", 64'(out_addr), 64'h0000_0240);
    check("R6 Y fallback tile", 64'(out_tile), 64'd0);
    check("R6 Y fallback mode", 64'(out_mode), 64'd0);
    @(negedge clk);
    finish_run();
  end

endmodule